// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block gathers a parameterized set of interrupt request lines, turns them into pending requests, and hands the most urgent eligible one to a processor through a small handshake. Each line has a priority, an enable and a detection mode, all set through a byte-wide configuration port. A programmable split divides every priority into a group field, which decides preemption, and a subpriority field, which only orders requests inside one group.

Handlers nest. An active stack records every handler that has started and not yet returned, along with the group it runs at. A new request may preempt only when its group value is strictly below the group on top of the stack. When a handler returns and another eligible request is waiting, the controller goes straight into that handler on a shortened path. Handler entry is modelled as a fixed cycle count; the register save, the vector fetch and the core itself lie outside.

The controller is built around four states. `ST_IDLE`: no handler runs. `ST_ENTRY`: a full entry is counting down. `ST_ACTIVE`: a handler runs. `ST_CHAIN`: a shortened entry follows a return. The transitions are: accept (`ST_IDLE` to `ST_ENTRY` on an eligible request), start (`ST_ENTRY` or `ST_CHAIN` to `ST_ACTIVE` when the count runs out), preempt (`ST_ACTIVE` to `ST_ENTRY` on a request of a strictly better group), chain (`ST_ACTIVE` to `ST_CHAIN` on a return with an eligible request waiting), resume (`ST_ACTIVE` stays in `ST_ACTIVE` on a return with nothing eligible and an older handler on the stack), and drain (`ST_ACTIVE` to `ST_IDLE` on a return that empties the stack).

Top module: `nest_irq_ctrl`

## Requirements
- R1: Line n has its configuration byte at address n, with bit 7 set for pulse mode, bit 6 set for enable and bits [PRIO_W-1:0] holding the priority. The group split sits at address N_IRQ, and a value above PRIO_W is stored as PRIO_W. After reset every line byte reads 0 and the split reads PRIO_W.
- R2: An enabled level-mode line is pending while its input is high and it is not on the active stack. If the input is still high when its handler returns, that return chains straight back into the same line.
- R3: An enabled pulse-mode line latches a pending request on a rising edge of its input and keeps it until the handler for that line starts.
- R4: A disabled line never becomes pending. Enabling it later does not deliver a pulse that arrived while it was disabled.
- R5: Among eligible requests, the lowest priority value wins. A tie goes to the lowest line index.
- R6: The group is the top `split` bits of the priority. A request preempts a running handler only when its group value is strictly below that handler's group. Subpriority never preempts.
- R7: A full entry raises `exc_req` and pulses `hdl_start` exactly ENTRY_CYCLES (12) cycles after `exc_req` rises. `exc_req` is low in the cycle of `hdl_start`.
- R8: A better request that arrives during an entry or chain countdown replaces the candidate in `exc_vec` without restarting the count. The line that starts is the last candidate.
- R9: A return with an eligible request waiting raises `exc_chain` together with `exc_req`, and the next `hdl_start` follows CHAIN_CYCLES (6) cycles later.
- R10: Each `hdl_start` raises `nest_depth` by one and shows the started line on `act_vec`. A return pops the top entry and uncovers the previous handler. The depth never exceeds 2^PRIO_W.
- R11: A return that empties the stack with nothing pending drops `act_valid` and leaves `exc_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IRQ | Request lines, synchronous to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(N_IRQ+1) | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| exc_req | output | 1 | Entry or chain countdown in progress |
| exc_chain | output | 1 | Current countdown is a chained entry |
| exc_vec | output | $clog2(N_IRQ) | Candidate line being entered |
| exc_return | input | 1 | Running handler returns (honoured in ST_ACTIVE) |
| hdl_start | output | 1 | One-cycle pulse: handler starts |
| act_valid | output | 1 | At least one handler is active |
| act_vec | output | $clog2(N_IRQ) | Line on top of the active stack |
| nest_depth | output | $clog2(2^PRIO_W+1) | Number of stacked handlers |

## Verification
The assertions assume that `exc_return` is raised only while a handler runs and that the group split is not rewritten while handlers are stacked, since a stored group would then disagree with a recomputed one. They also assume that a level line's request does not drop during its own entry countdown. The stimulus pulses `exc_return` only after the expected `hdl_start` has gone by. It changes the split only with the stack empty, and it holds level inputs high until the handler has started.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_ACTIVE,
        ST_CHAIN
    } nic_state_e;

    localparam int CFG_PULSE_BIT  = 7;
    localparam int CFG_ENABLE_BIT = 6;

endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs #(
    parameter int N_IRQ   = 8,
    parameter int PRIO_W  = 3,
    parameter int AW      = 4,
    parameter int SPLIT_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [AW-1:0]                addr,
    input  logic [7:0]                   wdata,
    output logic [7:0]                   rdata,
    output logic [N_IRQ-1:0][PRIO_W-1:0] prio,
    output logic [N_IRQ-1:0]             enable,
    output logic [N_IRQ-1:0]             pulse_mode,
    output logic [SPLIT_W-1:0]           split
);
    import nic_pkg::*;

    logic unused_wbits;
    assign unused_wbits = ^wdata[CFG_ENABLE_BIT-1:PRIO_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio       <= '0;
            enable     <= '0;
            pulse_mode <= '0;
            split      <= SPLIT_W'(PRIO_W);
        end else if (we) begin
            for (int i = 0; i < N_IRQ; i++) begin
                if (addr == AW'(i)) begin
                    prio[i]       <= wdata[PRIO_W-1:0];
                    enable[i]     <= wdata[CFG_ENABLE_BIT];
                    pulse_mode[i] <= wdata[CFG_PULSE_BIT];
                end
            end
            if (addr == AW'(N_IRQ)) begin
                if (wdata > 8'(PRIO_W))
                    split <= SPLIT_W'(PRIO_W);
                else
                    split <= wdata[SPLIT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (addr == AW'(i)) begin
                rdata[PRIO_W-1:0]     = prio[i];
                rdata[CFG_ENABLE_BIT] = enable[i];
                rdata[CFG_PULSE_BIT]  = pulse_mode[i];
            end
        end
        if (addr == AW'(N_IRQ))
            rdata[SPLIT_W-1:0] = split;
    end

endmodule

// File: rtl/nic_pending.sv
module nic_pending #(
    parameter int N_IRQ = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [N_IRQ-1:0] enable,
    input  logic [N_IRQ-1:0] pulse_mode,
    input  logic [N_IRQ-1:0] act_mask,
    input  logic             ack,
    input  logic [IDX_W-1:0] ack_idx,
    output logic [N_IRQ-1:0] pend
);
    logic [N_IRQ-1:0] irq_q;
    logic [N_IRQ-1:0] latch_q;
    logic [N_IRQ-1:0] rise;

    assign rise = irq_in & ~irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q   <= '0;
            latch_q <= '0;
        end else begin
            irq_q <= irq_in;
            for (int i = 0; i < N_IRQ; i++) begin
                if (!pulse_mode[i])
                    latch_q[i] <= 1'b0;
                else if (rise[i] && enable[i])
                    latch_q[i] <= 1'b1;
                else if (ack && ack_idx == IDX_W'(i))
                    latch_q[i] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        assign pend[g] = enable[g] &
                         (pulse_mode[g] ? latch_q[g] : (irq_in[g] & ~act_mask[g]));
    end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
    parameter int N_IRQ   = 8,
    parameter int PRIO_W  = 3,
    parameter int SPLIT_W = 2,
    parameter int IDX_W   = 3
) (
    input  logic [N_IRQ-1:0]             req,
    input  logic [N_IRQ-1:0][PRIO_W-1:0] prio,
    input  logic [SPLIT_W-1:0]           split,
    input  logic [PRIO_W:0]              thr_grp,
    output logic                         win_valid,
    output logic [IDX_W-1:0]             win_idx,
    output logic [PRIO_W-1:0]            win_grp
);
    logic [SPLIT_W-1:0]           shamt;
    logic [N_IRQ-1:0][PRIO_W-1:0] grp_v;
    logic [N_IRQ-1:0]             elig;
    logic [PRIO_W-1:0]            best;

    assign shamt = SPLIT_W'(PRIO_W) - split;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_grp
        assign grp_v[g] = prio[g] >> shamt;
        assign elig[g]  = req[g] && ({1'b0, grp_v[g]} < thr_grp);
    end

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best      = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (elig[i] && (!win_valid || prio[i] < best)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best      = prio[i];
            end
        end
    end

    assign win_grp = grp_v[win_idx];

endmodule

// File: rtl/nic_stack.sv
module nic_stack #(
    parameter int N_IRQ  = 8,
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 3,
    parameter int DW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [PRIO_W-1:0] push_grp,
    input  logic              pop,
    output logic [IDX_W-1:0]  top_idx,
    output logic [PRIO_W-1:0] top_grp,
    output logic [PRIO_W-1:0] prev_grp,
    output logic [DW-1:0]     depth,
    output logic [N_IRQ-1:0]  act_mask
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0]  idx_mem [DEPTH];
    logic [PRIO_W-1:0] grp_mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     top_ptr;
    logic [PW-1:0]     prev_ptr;

    assign wr_ptr   = PW'(depth);
    assign top_ptr  = PW'(depth - 1'b1);
    assign prev_ptr = PW'(depth - 2'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth    <= '0;
            act_mask <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                idx_mem[i] <= '0;
                grp_mem[i] <= '0;
            end
        end else if (push && depth < DW'(DEPTH)) begin
            idx_mem[wr_ptr]    <= push_idx;
            grp_mem[wr_ptr]    <= push_grp;
            depth              <= depth + 1'b1;
            act_mask[push_idx] <= 1'b1;
        end else if (pop && depth != '0) begin
            depth                       <= depth - 1'b1;
            act_mask[idx_mem[top_ptr]]  <= 1'b0;
        end
    end

    assign top_idx  = (depth != '0)     ? idx_mem[top_ptr]  : '0;
    assign top_grp  = (depth != '0)     ? grp_mem[top_ptr]  : '0;
    assign prev_grp = (depth >= DW'(2)) ? grp_mem[prev_ptr] : '0;

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int N_IRQ        = 8,
    parameter int PRIO_W       = 3,
    parameter int ENTRY_CYCLES = 12,
    parameter int CHAIN_CYCLES = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_IRQ-1:0]             irq_in,
    input  logic                         cfg_we,
    input  logic [$clog2(N_IRQ+1)-1:0]   cfg_addr,
    input  logic [7:0]                   cfg_wdata,
    output logic [7:0]                   cfg_rdata,
    output logic                         exc_req,
    output logic                         exc_chain,
    output logic [$clog2(N_IRQ)-1:0]     exc_vec,
    input  logic                         exc_return,
    output logic                         hdl_start,
    output logic                         act_valid,
    output logic [$clog2(N_IRQ)-1:0]     act_vec,
    output logic [$clog2((1<<PRIO_W)+1)-1:0] nest_depth
);
    import nic_pkg::*;

    localparam int IDX_W   = $clog2(N_IRQ);
    localparam int AW      = $clog2(N_IRQ + 1);
    localparam int SPLIT_W = $clog2(PRIO_W + 1);
    localparam int DEPTH   = 1 << PRIO_W;
    localparam int DW      = $clog2(DEPTH + 1);
    localparam int MAX_CYC = (ENTRY_CYCLES > CHAIN_CYCLES) ? ENTRY_CYCLES : CHAIN_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [PRIO_W:0] GRP_NONE = {1'b1, {PRIO_W{1'b0}}};

    nic_state_e state_q, state_d;

    logic [N_IRQ-1:0][PRIO_W-1:0] prio;
    logic [N_IRQ-1:0]             enable;
    logic [N_IRQ-1:0]             pulse_mode;
    logic [SPLIT_W-1:0]           split;
    logic [N_IRQ-1:0]             pend;
    logic [N_IRQ-1:0]             act_mask;
    logic [N_IRQ-1:0]             ret_clear;
    logic [PRIO_W:0]              thr_grp;
    logic                         win_valid;
    logic [IDX_W-1:0]             win_idx;
    logic [PRIO_W-1:0]            win_grp;
    logic [IDX_W-1:0]             top_idx;
    logic [PRIO_W-1:0]            top_grp;
    logic [PRIO_W-1:0]            prev_grp;
    logic [DW-1:0]                depth;
    logic [CNT_W-1:0]             cnt_q;
    logic [IDX_W-1:0]             cand_q;
    logic [PRIO_W-1:0]            cand_grp_q;
    logic                         ret_now;
    logic                         done;

    assign ret_now = (state_q == ST_ACTIVE) && exc_return;
    assign done    = ((state_q == ST_ENTRY) || (state_q == ST_CHAIN)) && (cnt_q == '0);

    always_comb begin
        for (int i = 0; i < N_IRQ; i++)
            ret_clear[i] = ret_now && (top_idx == IDX_W'(i));
    end

    always_comb begin
        if (ret_now)
            thr_grp = (depth >= DW'(2)) ? {1'b0, prev_grp} : GRP_NONE;
        else
            thr_grp = (depth != '0) ? {1'b0, top_grp} : GRP_NONE;
    end

    nic_cfg_regs #(
        .N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .AW(AW), .SPLIT_W(SPLIT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .prio(prio),
        .enable(enable), .pulse_mode(pulse_mode), .split(split)
    );

    nic_pending #(
        .N_IRQ(N_IRQ), .IDX_W(IDX_W)
    ) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .enable(enable),
        .pulse_mode(pulse_mode), .act_mask(act_mask & ~ret_clear),
        .ack(done), .ack_idx(cand_q), .pend(pend)
    );

    nic_arbiter #(
        .N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .SPLIT_W(SPLIT_W), .IDX_W(IDX_W)
    ) u_arb (
        .req(pend), .prio(prio), .split(split), .thr_grp(thr_grp),
        .win_valid(win_valid), .win_idx(win_idx), .win_grp(win_grp)
    );

    nic_stack #(
        .N_IRQ(N_IRQ), .DEPTH(DEPTH), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .DW(DW)
    ) u_stack (
        .clk(clk), .rst_n(rst_n), .push(done), .push_idx(cand_q),
        .push_grp(cand_grp_q), .pop(ret_now), .top_idx(top_idx),
        .top_grp(top_grp), .prev_grp(prev_grp), .depth(depth),
        .act_mask(act_mask)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_valid) state_d = ST_ENTRY;
            ST_ENTRY:  if (cnt_q == '0) state_d = ST_ACTIVE;
            ST_ACTIVE: begin
                if (exc_return) begin
                    if (win_valid)            state_d = ST_CHAIN;
                    else if (depth > DW'(1))  state_d = ST_ACTIVE;
                    else                      state_d = ST_IDLE;
                end else if (win_valid) begin
                    state_d = ST_ENTRY;
                end
            end
            ST_CHAIN:  if (cnt_q == '0) state_d = ST_ACTIVE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            cand_q     <= '0;
            cand_grp_q <= '0;
        end else begin
            if (state_d == ST_ENTRY && state_q != ST_ENTRY)
                cnt_q <= CNT_W'(ENTRY_CYCLES - 1);
            else if (state_d == ST_CHAIN && state_q != ST_CHAIN)
                cnt_q <= CNT_W'(CHAIN_CYCLES - 1);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            if (win_valid && (state_d == ST_ENTRY || state_d == ST_CHAIN)) begin
                cand_q     <= win_idx;
                cand_grp_q <= win_grp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hdl_start <= 1'b0;
        else        hdl_start <= done;
    end

    always_comb begin
        exc_req    = (state_q == ST_ENTRY) || (state_q == ST_CHAIN);
        exc_chain  = (state_q == ST_CHAIN);
        exc_vec    = cand_q;
        act_valid  = (depth != '0);
        act_vec    = top_idx;
        nest_depth = depth;
    end

endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
    parameter int IDX_W        = 3,
    parameter int DW           = 4,
    parameter int DEPTH        = 8,
    parameter int ENTRY_CYCLES = 12,
    parameter int CHAIN_CYCLES = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_req,
    input logic             exc_chain,
    input logic [IDX_W-1:0] exc_vec,
    input logic             exc_return,
    input logic             hdl_start,
    input logic             act_valid,
    input logic [IDX_W-1:0] act_vec,
    input logic [DW-1:0]    nest_depth
);
    logic [15:0] lat_cnt;
    logic        chain_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt    <= '0;
            chain_seen <= 1'b0;
        end else if (exc_req) begin
            lat_cnt    <= lat_cnt + 1'b1;
            chain_seen <= exc_chain;
        end else begin
            lat_cnt <= '0;
        end
    end

    assert_entry_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdl_start && !chain_seen) |-> (lat_cnt == 16'(ENTRY_CYCLES)));

    assert_chain_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hdl_start && chain_seen) |-> (lat_cnt == 16'(CHAIN_CYCLES)));

    assert_req_low_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_start |-> !exc_req);

    assert_started_is_candidate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_start |-> (act_vec == $past(exc_vec)));

    assert_depth_grows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_start |-> (nest_depth == DW'($past(nest_depth) + 1'b1)));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        nest_depth <= DW'(DEPTH));

    assert_chain_after_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_chain) |-> $past(exc_return));

    assert_drain_on_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_valid) |-> $past(exc_return));

endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(
    .IDX_W(IDX_W), .DW(DW), .DEPTH(DEPTH),
    .ENTRY_CYCLES(ENTRY_CYCLES), .CHAIN_CYCLES(CHAIN_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_chain(exc_chain),
    .exc_vec(exc_vec), .exc_return(exc_return), .hdl_start(hdl_start),
    .act_valid(act_valid), .act_vec(act_vec), .nest_depth(nest_depth)
);

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_IRQ      = 8;
    localparam int PRIO_W     = 3;

    typedef struct packed {
        logic [2:0] vec;
        logic       chain;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       exc_req;
    logic       exc_chain;
    logic [2:0] exc_vec;
    logic       exc_return = 1'b0;
    logic       hdl_start;
    logic       act_valid;
    logic [2:0] act_vec;
    logic [3:0] nest_depth;

    int        n_checks = 0;
    int        n_fail   = 0;
    int        cyc      = 0;
    int        start_cyc = 0;
    bit        req_prev = 1'b0;
    bit        chain_at_rise = 1'b0;
    bit        finished = 1'b0;
    exp_item_t exp_q[$];

    nest_irq_ctrl #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_nest_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .exc_req(exc_req), .exc_chain(exc_chain), .exc_vec(exc_vec),
        .exc_return(exc_return), .hdl_start(hdl_start), .act_valid(act_valid),
        .act_vec(act_vec), .nest_depth(nest_depth)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard at every handler start.
    always @(negedge clk) begin
        if (rst_n) begin
            if (exc_req && !req_prev) begin
                start_cyc     = cyc;
                chain_at_rise = exc_chain;
            end
            req_prev = exc_req;
            if (hdl_start) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected handler start", int'(act_vec), -1);
                end else begin
                    exp_item_t it;
                    int lat;
                    int exp_lat;
                    it = exp_q.pop_front();
                    lat = cyc - start_cyc;
                    exp_lat = it.chain ? 6 : 12;
                    check(act_vec == it.vec, "R5/R8 started line", int'(act_vec), int'(it.vec));
                    check(chain_at_rise == it.chain, "R9 chain flag", int'(chain_at_rise), int'(it.chain));
                    check(lat == exp_lat, "R7/R9 entry latency", lat, exp_lat);
                end
            end
        end
    end

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    task automatic expect_start(input logic [2:0] vec, input logic chain);
        exp_item_t it;
        it.vec = vec;
        it.chain = chain;
        exp_q.push_back(it);
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_expect(input logic [3:0] a, input logic [7:0] d, input string tag);
        cfg_addr = a;
        #1;
        check(cfg_rdata == d, tag, int'(cfg_rdata), int'(d));
    endtask

    task automatic pulse(input logic [7:0] m);
        @(posedge clk); #1;
        irq_in = irq_in | m;
        @(posedge clk); #1;
        irq_in = irq_in & ~m;
    endtask

    task automatic ret();
        @(posedge clk); #1;
        exc_return = 1'b1;
        @(posedge clk); #1;
        exc_return = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // Reset state (R1, R11)
        check(exc_req == 1'b0, "R11 reset exc_req", int'(exc_req), 0);
        check(act_valid == 1'b0, "R11 reset act_valid", int'(act_valid), 0);
        check(nest_depth == 4'd0, "R10 reset depth", int'(nest_depth), 0);
        cfg_expect(4'd0, 8'h00, "R1 reset line byte");
        cfg_expect(4'd8, 8'd3, "R1 reset split");

        // R1 readback; split clamps above PRIO_W
        cfg_write(4'd5, 8'hC6);
        cfg_expect(4'd5, 8'hC6, "R1 line readback");
        cfg_write(4'd8, 8'd7);
        cfg_expect(4'd8, 8'd3, "R1 split clamp");

        // R3/R6/R10: pulse line 5 (prio 6), then line 1 (prio 2) preempts
        cfg_write(4'd1, 8'hC2);
        expect_start(3'd5, 1'b0);
        pulse(8'h20);
        tick(16);
        check(act_vec == 3'd5, "R3 pulse entered", int'(act_vec), 5);
        expect_start(3'd1, 1'b0);
        pulse(8'h02);
        tick(16);
        check(nest_depth == 4'd2, "R6 preempt depth", int'(nest_depth), 2);
        check(act_vec == 3'd1, "R10 top after preempt", int'(act_vec), 1);
        ret();
        tick(2);
        check(nest_depth == 4'd1, "R10 depth after pop", int'(nest_depth), 1);
        check(act_vec == 3'd5, "R10 resumed line", int'(act_vec), 5);
        check(exc_req == 1'b0, "R10 resume without entry", int'(exc_req), 0);

        // R6/R9: same group does not preempt, chains on return
        cfg_write(4'd3, 8'hC6);
        pulse(8'h08);
        tick(5);
        check(exc_req == 1'b0, "R6 equal group no preempt", int'(exc_req), 0);
        expect_start(3'd3, 1'b1);
        ret();
        tick(10);
        check(act_vec == 3'd3, "R9 chained line", int'(act_vec), 3);
        check(nest_depth == 4'd1, "R9 chain keeps depth", int'(nest_depth), 1);
        ret();
        tick(3);
        check(act_valid == 1'b0, "R11 drained", int'(act_valid), 0);
        check(exc_req == 1'b0, "R11 no entry after drain", int'(exc_req), 0);

        // R8: late arrival replaces the candidate
        expect_start(3'd1, 1'b0);
        expect_start(3'd5, 1'b1);
        pulse(8'h20);
        tick(2);
        pulse(8'h02);
        tick(16);
        check(act_vec == 3'd1, "R8 late arrival wins", int'(act_vec), 1);
        check(nest_depth == 4'd1, "R8 replaced not nested", int'(nest_depth), 1);
        ret();
        tick(10);
        check(act_vec == 3'd5, "R8 replaced line chains later", int'(act_vec), 5);
        ret();
        tick(3);

        // R5: tie on priority goes to the lower index
        cfg_write(4'd3, 8'hC5);
        cfg_write(4'd6, 8'hC5);
        expect_start(3'd3, 1'b0);
        expect_start(3'd6, 1'b1);
        pulse(8'h48);
        tick(16);
        check(act_vec == 3'd3, "R5 tie lower index", int'(act_vec), 3);
        ret();
        tick(10);
        check(act_vec == 3'd6, "R5 tie second", int'(act_vec), 6);
        ret();
        tick(3);

        // R6: split of 1; subpriority orders but never preempts
        cfg_write(4'd8, 8'd1);
        cfg_expect(4'd8, 8'd1, "R1 split write");
        cfg_write(4'd4, 8'hC3);
        cfg_write(4'd6, 8'hC1);
        cfg_write(4'd0, 8'hC2);
        expect_start(3'd4, 1'b0);
        pulse(8'h10);
        tick(16);
        pulse(8'h41);
        tick(5);
        check(exc_req == 1'b0, "R6 subpriority no preempt", int'(exc_req), 0);
        check(act_vec == 3'd4, "R6 handler kept", int'(act_vec), 4);
        expect_start(3'd6, 1'b1);
        expect_start(3'd0, 1'b1);
        ret();
        tick(10);
        check(act_vec == 3'd6, "R6 better sub first", int'(act_vec), 6);
        ret();
        tick(10);
        check(act_vec == 3'd0, "R6 next sub", int'(act_vec), 0);
        ret();
        tick(3);

        // R4: disabled line neither pends nor delivers later
        cfg_write(4'd7, 8'h80);
        pulse(8'h80);
        tick(4);
        check(exc_req == 1'b0, "R4 disabled no request", int'(exc_req), 0);
        cfg_write(4'd7, 8'hC0);
        tick(4);
        check(exc_req == 1'b0, "R4 enable later no request", int'(exc_req), 0);
        check(act_valid == 1'b0, "R4 nothing active", int'(act_valid), 0);

        // R2: level line re-enters while still high at return
        cfg_write(4'd2, 8'h44);
        expect_start(3'd2, 1'b0);
        expect_start(3'd2, 1'b1);
        irq_in[2] = 1'b1;
        tick(16);
        check(act_vec == 3'd2, "R2 level entered", int'(act_vec), 2);
        ret();
        tick(10);
        check(act_vec == 3'd2, "R2 level re-entered", int'(act_vec), 2);
        check(nest_depth == 4'd1, "R2 not nested on itself", int'(nest_depth), 1);
        irq_in[2] = 1'b0;
        ret();
        tick(3);
        check(act_valid == 1'b0, "R2 level low drains", int'(act_valid), 0);
        tick(3);
        check(exc_req == 1'b0, "R2 no re-pend when low", int'(exc_req), 0);

        check(exp_q.size() == 0, "R7 all expected starts seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule